// File: doc/BRIEF.md
# Multi-Lane DDR Word Deserializer

This block sits behind the pad-level DDR capture flops of a source-synchronous receiver. Several lanes share one forwarded clock. Every cycle, each lane delivers two already-captured bits: one taken on the rising edge and one on the falling edge. The block gathers these bits into 10-bit words. It builds each word from two 5-bit half-words. The first half, called the even half, is latched as soon as its five bits have arrived. At the word boundary it is joined with the second half, called the odd half. The joined word is then presented together with a one-cycle valid strobe. A single shared sequencer times all lanes, so every lane presents its word on the same cycle, once every five clock cycles.

Framing is set separately for each lane through a slip pulse. Each pulse moves that lane's word boundary one serial bit later in the stream. Ten pulses bring the boundary back to its starting position. A framing controller outside the block can watch for a known idle word and pulse slip until the idle word appears. The slip does not stall the word timing. Instead it changes which stretch of bit history is read at the fixed word boundary.

The shared sequencer has two states. ST_PRIME is entered on reset and lasts for the first five cycles. No word is emitted in this state. It takes the transition "primed" to ST_RUN on the cycle its phase counter reaches its last value. ST_RUN then loops on itself ("run"). In ST_RUN, phase 0 is the word boundary, where a word is emitted and pending slips take effect, and phase 3 is the even-half capture point. In ST_PRIME, phase 0 still applies slips and phase 3 still captures the even half, but no word is emitted.

Top module: `ddr_fabric_deser`

## Requirements
- R1: While the synchronous reset is high, and after it until the first word appears, valid_o is 0 and word_o is all zeros.
- R2: Call the first rising edge with reset low edge 0. The first valid_o pulse is seen in the cycle after edge 5. Its words hold the 10 bits delivered on edges 0 to 4.
- R3: After the first pulse, valid_o is high for exactly one cycle in every five. All lanes present their words in that same cycle, and word_o does not change between pulses.
- R4: Lane n occupies word_o[10n+9:10n]. Within a cycle, the rise_i bit precedes the fall_i bit in time. The earliest bit of a word lands in bit 9 of its slice, and later bits follow toward bit 0.
- R5: Each word is the even half-word, made of its first five bits, in bits 9..5, followed by the odd half-word, made of its last five bits, in bits 4..0.
- R6: After reset the boundary is aligned: the word presented after edge 5k holds stream bits 10k-10 to 10k-1. Each slip pulse moves that lane's boundary one bit later, so later words start one stream bit further on.
- R7: A slip pulse sampled at a word-boundary edge (5k) or at any earlier edge since the previous boundary takes effect at that boundary edge. The word emitted at that boundary is unchanged, and every later word is shifted. Slip pulses are at least six cycles apart.
- R8: Ten slip pulses on a lane return its boundary to the starting alignment.
- R9: A slip pulse on one lane changes neither the words nor the timing of any other lane.
- R10: If a lane's stream is a repeated non-periodic idle word starting at bit offset o (0 ≤ o ≤ 9), then exactly o slip pulses make that lane present the idle word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Forwarded-clock domain clock |
| rst | input | 1 | Synchronous reset, active high |
| rise_i | input | LANES | Per lane: bit captured on the rising edge, the earlier bit |
| fall_i | input | LANES | Per lane: bit captured on the falling edge, the later bit |
| slip_i | input | LANES | Per lane: one-cycle pulse that moves the word boundary one bit later |
| word_o | output | LANES*WORD_W | Parallel words, lane n in bits [WORD_W*n +: WORD_W] |
| valid_o | output | 1 | One-cycle strobe, common to all lanes, marking new words |

## Verification
The checks assume that a lane never receives a second slip pulse while an earlier one is still waiting for its word boundary. A guard assertion states this assumption. The stimulus keeps within it: a slip is issued at most once per word period, and the idle-word hunt lets one whole word go by after each pulse before it judges the alignment again. Reset is held for several edges before the checks start. Data bits come from a stream whose value is known for every bit index, and bits before edge 0 count as zero. With that, every expected word can be worked out from the edge index and the slip history.

// File: rtl/ddrw_pkg.sv
package ddrw_pkg;

    // Shared word sequencer states
    typedef enum logic [0:0] {
        ST_PRIME = 1'b0,   // first word period after reset, nothing emitted
        ST_RUN   = 1'b1    // steady state, one word per period
    } seq_state_t;

endpackage

// File: rtl/ddrw_word_seq.sv
module ddrw_word_seq
    import ddrw_pkg::*;
#(
    parameter int CYC    = 5,   // clock cycles per word
    parameter int CAP_PH = 3    // phase at which the even half is captured
) (
    input  logic clk,
    input  logic rst,
    output logic cap_o,    // capture even half this edge
    output logic slot_o,   // word boundary: apply slips
    output logic emit_o,   // word boundary with word emission
    output logic valid_o
);

    localparam int CNT_W = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [CNT_W-1:0] LAST_PH = CNT_W'(CYC - 1);
    localparam logic [CNT_W-1:0] CAP_V   = CNT_W'(CAP_PH);

    seq_state_t       state, state_n;
    logic [CNT_W-1:0] ph;

    // state register and phase counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_PRIME;
            ph    <= '0;
        end else begin
            state <= state_n;
            ph    <= (ph == LAST_PH) ? '0 : ph + 1'b1;
        end
    end

    // transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_PRIME: if (ph == LAST_PH) state_n = ST_RUN;   // primed
            ST_RUN:   state_n = ST_RUN;                      // run
            default:  state_n = ST_PRIME;
        endcase
    end

    // strobes per state
    always_comb begin
        cap_o  = 1'b0;
        slot_o = 1'b0;
        emit_o = 1'b0;
        unique case (state)
            ST_PRIME: begin
                cap_o  = (ph == CAP_V);
                slot_o = (ph == '0);
            end
            ST_RUN: begin
                cap_o  = (ph == CAP_V);
                slot_o = (ph == '0);
                emit_o = (ph == '0);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) valid_o <= 1'b0;
        else     valid_o <= emit_o;
    end

    // ---------------- assertions ----------------
    localparam int MON_W = $clog2(CYC + 2) + 1;
    localparam logic [MON_W-1:0] MON_MAX = MON_W'(CYC + 1);

    logic [MON_W-1:0] since_rst;
    logic [MON_W-1:0] gap;
    logic             seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
            gap       <= '0;
            seen      <= 1'b0;
        end else begin
            if (since_rst != MON_MAX) since_rst <= since_rst + 1'b1;
            if (valid_o) begin
                gap  <= MON_W'(1);
                seen <= 1'b1;
            end else if (gap != MON_MAX) begin
                gap <= gap + 1'b1;
            end
        end
    end

    a_r2_no_early_valid: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> since_rst >= MON_MAX);

    a_r3_period_exact: assert property (@(posedge clk) disable iff (rst)
        (valid_o && seen) |-> gap == MON_W'(CYC));

    a_r3_period_no_miss: assert property (@(posedge clk) disable iff (rst)
        (seen && gap == MON_W'(CYC)) |-> valid_o);

    a_r3_single_cycle: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

endmodule

// File: rtl/ddrw_lane.sv
module ddrw_lane #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              slip_i,
    input  logic              cap_i,
    input  logic              slot_i,
    input  logic              emit_i,
    output logic [WORD_W-1:0] word_o
);

    localparam int HALF_W = WORD_W / 2;
    localparam int LEAD   = HALF_W / 2;                 // cycles between even capture and emit
    localparam int BASE   = HALF_W - 2 * LEAD;          // even-half offset at capture time
    localparam int SR_W   = 2 * WORD_W - 1 - 2 * LEAD;  // history depth
    localparam int LAG_W  = $clog2(WORD_W);
    localparam logic [LAG_W-1:0] LAG_TOP = LAG_W'(WORD_W - 1);

    logic [SR_W-1:0]   hist;     // newest bit at index 0
    logic [LAG_W-1:0]  lag;      // bits between newest bit and word end
    logic              pend;
    logic [HALF_W-1:0] even_q;
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist   <= '0;
            lag    <= '0;
            pend   <= 1'b0;
            even_q <= '0;
            word_q <= '0;
        end else begin
            hist <= {hist[SR_W-3:0], rise_i, fall_i};
            if (slot_i) begin
                pend <= 1'b0;
                if (pend || slip_i)
                    lag <= (lag == '0) ? LAG_TOP : lag - 1'b1;
            end else if (slip_i) begin
                pend <= 1'b1;
            end
            if (cap_i)
                even_q <= hist[int'(lag) + BASE +: HALF_W];
            if (emit_i)
                word_q <= {even_q, hist[int'(lag) +: HALF_W]};
        end
    end

    assign word_o = word_q;

    // ---------------- assertions ----------------
    logic past_ok;
    always_ff @(posedge clk) past_ok <= !rst;

    a_r7_slip_spacing: assert property (@(posedge clk) disable iff (rst)
        slip_i |-> !pend);

    a_r7_lag_only_at_slot: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(slot_i)) |-> $stable(lag));

    a_r6_slip_moves_lag: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(slot_i) && $past(slip_i)) |-> lag != $past(lag));

    a_r8_lag_wraps: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(lag) == '0 && lag != '0) |-> lag == LAG_TOP);

    a_r3_word_hold: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(emit_i)) |-> $stable(word_q));

endmodule

// File: rtl/ddr_fabric_deser.sv
module ddr_fabric_deser #(
    parameter int LANES  = 3,
    parameter int WORD_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES-1:0]        rise_i,
    input  logic [LANES-1:0]        fall_i,
    input  logic [LANES-1:0]        slip_i,
    output logic [LANES*WORD_W-1:0] word_o,
    output logic                    valid_o
);

    localparam int HALF_W = WORD_W / 2;
    localparam int CYC    = WORD_W / 2;
    localparam int LEAD   = HALF_W / 2;
    localparam int CAP_PH = CYC - LEAD;

    logic cap, slot, emit;

    ddrw_word_seq #(
        .CYC    (CYC),
        .CAP_PH (CAP_PH)
    ) seq_i (
        .clk     (clk),
        .rst     (rst),
        .cap_o   (cap),
        .slot_o  (slot),
        .emit_o  (emit),
        .valid_o (valid_o)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ddrw_lane #(
            .WORD_W (WORD_W)
        ) lane_i (
            .clk    (clk),
            .rst    (rst),
            .rise_i (rise_i[g]),
            .fall_i (fall_i[g]),
            .slip_i (slip_i[g]),
            .cap_i  (cap),
            .slot_i (slot),
            .emit_i (emit),
            .word_o (word_o[g*WORD_W +: WORD_W])
        );
    end

endmodule

// File: tb/ddr_fabric_deser_tb_top.sv
module ddr_fabric_deser_tb_top;

    localparam int L = 3;
    localparam int W = 10;
    localparam logic [W-1:0] IDLE = 10'b1101000110;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic           rst;
    logic [L-1:0]   rise, fall, slip;
    logic [L*W-1:0] word;
    logic           valid;

    ddr_fabric_deser #(.LANES(L), .WORD_W(W)) dut_i (
        .clk(clk), .rst(rst), .rise_i(rise), .fall_i(fall),
        .slip_i(slip), .word_o(word), .valid_o(valid)
    );

    int ecnt;   // rising edges since reset release
    always @(posedge clk) begin
        if (rst) ecnt <= 0;
        else     ecnt <= ecnt + 1;
    end

    int n_chk = 0;
    int n_bad = 0;
    int mode;
    int off    [L];
    int lag_m  [L];
    bit pend_m [L];

    function automatic logic [W-1:0] pat_word(int ln, int w);
        return W'(w * 73 + ln * 291 + 17);
    endfunction

    function automatic logic gbit(int ln, int n);
        logic [W-1:0] v;
        int m;
        if (n < 0) return 1'b0;
        if (mode == 0) begin
            v = pat_word(ln, n / W);
            return v[W-1-(n % W)];
        end
        m = (((n - off[ln]) % W) + W) % W;
        return IDLE[W-1-m];
    endfunction

    function automatic logic [W-1:0] exp_word(int ln, int k);
        logic [W-1:0] v;
        int last;
        last = 2 * k - 1;
        for (int j = 0; j < W; j++)
            v[W-1-j] = gbit(ln, last - lag_m[ln] - (W - 1) + j);
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic drive(input logic [L-1:0] s);
        for (int ln = 0; ln < L; ln++) begin
            rise[ln]   = gbit(ln, 2 * ecnt);
            fall[ln]   = gbit(ln, 2 * ecnt + 1);
            pend_m[ln] = pend_m[ln] | s[ln];
        end
        slip = s;
    endtask

    // one cycle: sample outputs, update slip model, drive next edge
    task automatic step(input logic [L-1:0] s, input string req);
        bit exp_v;
        @(negedge clk);
        exp_v = (ecnt >= 6) && (ecnt % 5 == 1);
        check(valid == exp_v, (ecnt < 6) ? "R2" : req, "valid",
              W'(valid), W'(exp_v));
        for (int ln = 0; ln < L; ln++) begin
            if (ecnt < 6)
                check(word[ln*W +: W] == '0, "R1", $sformatf("lane%0d word", ln),
                      word[ln*W +: W], '0);
            else if (exp_v)
                check(word[ln*W +: W] == exp_word(ln, ecnt - 1), req,
                      $sformatf("lane%0d word", ln),
                      word[ln*W +: W], exp_word(ln, ecnt - 1));
        end
        if (ecnt % 5 == 1) begin
            for (int ln = 0; ln < L; ln++) begin
                if (pend_m[ln]) begin
                    lag_m[ln]  = (lag_m[ln] == 0) ? W - 1 : lag_m[ln] - 1;
                    pend_m[ln] = 1'b0;
                end
            end
        end
        drive(s);
    endtask

    task automatic do_reset();
        rst  = 1'b1;
        slip = '0;
        rise = '0;
        fall = '0;
        repeat (3) @(negedge clk);
        check(valid == 1'b0, "R1", "valid in reset", W'(valid), '0);
        for (int ln = 0; ln < L; ln++)
            check(word[ln*W +: W] == '0, "R1", "word in reset", word[ln*W +: W], '0);
        for (int ln = 0; ln < L; ln++) begin
            lag_m[ln]  = 0;
            pend_m[ln] = 1'b0;
        end
        rst = 1'b0;
        drive('0);
    endtask

    task automatic t_reset_prime();
        mode = 0;
        do_reset();
        repeat (12) step('0, "R2");
    endtask

    task automatic t_aligned();
        mode = 0;
        do_reset();
        repeat (60) step('0, "R3 R4 R5 R6");
    endtask

    task automatic t_slip_one();
        mode = 0;
        do_reset();
        repeat (13) step('0, "R6");
        step(3'b010, "R6");
        repeat (30) step('0, "R6 R9");
    endtask

    task automatic t_slip_at_slot();
        mode = 0;
        do_reset();
        repeat (12) step('0, "R7");
        while ((ecnt + 1) % 5 != 0) step('0, "R7");
        step(3'b001, "R7");   // pulse on a boundary edge
        repeat (8) step('0, "R7");
        while ((ecnt + 1) % 5 != 4) step('0, "R7");
        step(3'b100, "R7");   // pulse one edge before a boundary
        repeat (20) step('0, "R7 R9");
    endtask

    task automatic t_slip_wrap();
        mode = 0;
        do_reset();
        repeat (8) step('0, "R8");
        for (int i = 0; i < 10; i++) begin
            step(3'b101, "R8");
            repeat (9) step('0, "R8");
        end
        repeat (15) step('0, "R8");
        for (int ln = 0; ln < L; ln++)
            check(lag_m[ln] == 0, "R8", "model lag after ten slips", W'(lag_m[ln]), '0);
        // after ten slips the word must equal the unslipped framing
        @(negedge clk);
        while (!(ecnt >= 6 && ecnt % 5 == 1)) begin
            drive('0);
            @(negedge clk);
        end
        for (int ln = 0; ln < L; ln++)
            check(word[ln*W +: W] == pat_word(ln, (2 * (ecnt - 1)) / W - 1), "R8",
                  $sformatf("lane%0d realigned", ln),
                  word[ln*W +: W], pat_word(ln, (2 * (ecnt - 1)) / W - 1));
        drive('0);
    endtask

    task automatic t_hunt();
        int          nslip [L];
        bit          skip  [L];
        logic [L-1:0] m;
        mode   = 1;
        off[0] = 3;
        off[1] = 7;
        off[2] = 0;
        do_reset();
        for (int ln = 0; ln < L; ln++) begin
            nslip[ln] = 0;
            skip[ln]  = 1'b0;
        end
        m = '0;
        for (int c = 0; c < 130; c++) begin
            step(m, "R10");
            m = '0;
            if (ecnt >= 6 && ecnt % 5 == 1) begin
                for (int ln = 0; ln < L; ln++) begin
                    if (skip[ln]) skip[ln] = 1'b0;
                    else if (word[ln*W +: W] != IDLE) begin
                        m[ln]     = 1'b1;
                        skip[ln]  = 1'b1;
                        nslip[ln] = nslip[ln] + 1;
                    end
                end
            end
        end
        for (int ln = 0; ln < L; ln++) begin
            check(nslip[ln] == off[ln], "R10", $sformatf("lane%0d slip count", ln),
                  W'(nslip[ln]), W'(off[ln]));
            check(word[ln*W +: W] == IDLE, "R10", $sformatf("lane%0d idle", ln),
                  word[ln*W +: W], IDLE);
        end
    endtask

    initial begin
        mode = 0;
        for (int ln = 0; ln < L; ln++) off[ln] = 0;
        t_reset_prime();
        t_aligned();
        t_slip_one();
        t_slip_at_slot();
        t_slip_wrap();
        t_hunt();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule